// File: doc/BRIEF.md
# GPIO Bank with Event Detection and Dual Interrupt Lines

This block is a 32-pin general-purpose I/O bank on a simple 32-bit register bus. A bus access has a byte address, a write strobe and write data, and it returns read data. Software picks the direction of each pin with an output-enable register, drives outputs through an output latch, and reads input levels through a synchronized data-in view. The output latch can also be changed atomically through a set alias and a clear alias.

Each pin can watch for a low level, a high level, a rising edge and a falling edge, in any combination. A detected event latches into one shared raw status register. Two interrupt lines are driven from that status, each through its own enable mask. Each line has its own write-1 set and write-1 clear aliases for the mask, and its own masked status view where a written 1 acknowledges the event. Level events keep coming back while the level persists. Edge events stay latched until software acknowledges them.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, output-enable reads 0xFFFFFFFF (every pin is an input), the data-out latch, the detect registers, both enable masks and the status are 0, and both interrupt lines are low.
- R2: Offset 0x000 reads 0x50600801 and ignores writes. Any offset not listed in these requirements reads 0, and a write to it changes no state.
- R3: Offset 0x134 is the read/write output-enable register. Bit n set to 1 makes pin n an input; set to 0 it drives the output latch. `pin_oe_n` presents the register value.
- R4: Offset 0x13C is the read/write data-out latch, and `pin_out` presents it.
- R5: A write to 0x194 sets every latch bit written as 1, and a write to 0x190 clears every latch bit written as 1. Latch bits written as 0 keep their value.
- R6: Offset 0x138 returns `pin_in` after a two-flop synchronizer. A pin change is readable after the second rising clock edge.
- R7: Offset 0x140 enables low-level detection and 0x144 enables high-level detection. While an enabled level is present, the pin's status bit is set again on every cycle, so an acknowledge does not keep it cleared.
- R8: Offset 0x148 enables rising-edge detection and 0x14C enables falling-edge detection, with both bits set giving both edges. An edge compares the current synchronized sample with the previous one. An edge status bit stays set until it is acknowledged.
- R9: Offsets 0x024 and 0x028 both read the raw status and ignore writes. Offsets 0x02C and 0x030 read status AND mask 0 and status AND mask 1. Writing 1 to a bit at either masked offset clears that status bit, and writing 0 has no effect.
- R10: Offsets 0x034 and 0x038 set mask bits written as 1 for line 0 and line 1. Offsets 0x03C and 0x040 clear mask bits written as 1. Bits written as 0 are left unchanged. All four offsets read back their line's mask.
- R11: `irq0` and `irq1` are active-high registered outputs. In each cycle a line equals the OR of status AND its mask from the cycle before.
- R12: When a new event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output latch value |
| pin_oe_n | output | 32 | Output-enable register, 1 = input |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
The assertions assume that the bus carries at most one access per clock, and that address, strobe and data are known and stable around the rising edge. Pins may change at any time, because only the synchronizer samples them. The stimulus changes bus and pin inputs only on the falling edge, never drives X, and holds reset for several cycles before the first access. Random bursts draw their addresses mostly from the mapped offsets so that acknowledges, alias writes and detect reconfiguration overlap with live pin edges. A directed sequence lines an acknowledge up with a fresh edge on the same bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BANK_PINS   = 32;
  localparam int unsigned BANK_ADDR_W = 12;

  localparam logic [11:0] OFS_ID        = 12'h000;
  localparam logic [11:0] OFS_RAW_A     = 12'h024;
  localparam logic [11:0] OFS_RAW_B     = 12'h028;
  localparam logic [11:0] OFS_PEND_A    = 12'h02C;
  localparam logic [11:0] OFS_PEND_B    = 12'h030;
  localparam logic [11:0] OFS_MSET_A    = 12'h034;
  localparam logic [11:0] OFS_MSET_B    = 12'h038;
  localparam logic [11:0] OFS_MCLR_A    = 12'h03C;
  localparam logic [11:0] OFS_MCLR_B    = 12'h040;
  localparam logic [11:0] OFS_DIR       = 12'h134;
  localparam logic [11:0] OFS_SAMPLE    = 12'h138;
  localparam logic [11:0] OFS_LATCH     = 12'h13C;
  localparam logic [11:0] OFS_WATCH_LO  = 12'h140;
  localparam logic [11:0] OFS_WATCH_HI  = 12'h144;
  localparam logic [11:0] OFS_WATCH_UP  = 12'h148;
  localparam logic [11:0] OFS_WATCH_DN  = 12'h14C;
  localparam logic [11:0] OFS_LATCH_CLR = 12'h190;
  localparam logic [11:0] OFS_LATCH_SET = 12'h194;

  localparam logic [31:0] ID_VALUE = 32'h5060_0801;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= pin_in;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= '0;
      else        chain[k] <= chain[k-1];
    end
  end

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] watch_lo,
  input  logic [W-1:0] watch_hi,
  input  logic [W-1:0] watch_up,
  input  logic [W-1:0] watch_dn,
  input  logic [W-1:0] ack,
  input  logic [W-1:0] mask_a,
  input  logic [W-1:0] mask_b,
  output logic [W-1:0] status,
  output logic         irq0,
  output logic         irq1
);
  function automatic logic [W-1:0] find_events(
    input logic [W-1:0] lo, hi, up, dn, now, was);
    return (lo & ~now) | (hi & now) | (up & now & ~was) | (dn & ~now & was);
  endfunction

  function automatic logic any_pending(input logic [W-1:0] st, msk);
    return |(st & msk);
  endfunction

  logic [W-1:0] events;
  assign events = find_events(watch_lo, watch_hi, watch_up, watch_dn, cur, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq0   <= 1'b0;
      irq1   <= 1'b0;
    end else begin
      status <= (status & ~ack) | events;
      irq0   <= any_pending(status, mask_a);
      irq1   <= any_pending(status, mask_b);
    end
  end

  assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((status & $past(events)) == $past(events)));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((status & $past(ack & ~events)) == '0));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status & ~ack) & ~status) == '0));

  assert_line0_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq0 == $past(|(status & mask_a))));

  assert_line1_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq1 == $past(|(status & mask_b))));
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cur,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir_n,
  output logic [W-1:0]      latch,
  output logic [W-1:0]      watch_lo,
  output logic [W-1:0]      watch_hi,
  output logic [W-1:0]      watch_up,
  output logic [W-1:0]      watch_dn,
  output logic [W-1:0]      mask_a,
  output logic [W-1:0]      mask_b,
  output logic [W-1:0]      ack
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  function automatic logic [W-1:0] w1_update(
    input logic [W-1:0] old, input logic [W-1:0] d, input logic do_set, input logic do_clr);
    logic [W-1:0] r;
    r = old;
    if (do_set) r = r | d;
    if (do_clr) r = r & ~d;
    return r;
  endfunction

  logic wr_dir, wr_latch, wr_lset, wr_lclr;
  logic wr_lo, wr_hi, wr_up, wr_dn;
  logic wr_mset_a, wr_mclr_a, wr_mset_b, wr_mclr_b;
  logic wr_pend;

  assign wr_dir    = we && hit(addr, OFS_DIR);
  assign wr_latch  = we && hit(addr, OFS_LATCH);
  assign wr_lset   = we && hit(addr, OFS_LATCH_SET);
  assign wr_lclr   = we && hit(addr, OFS_LATCH_CLR);
  assign wr_lo     = we && hit(addr, OFS_WATCH_LO);
  assign wr_hi     = we && hit(addr, OFS_WATCH_HI);
  assign wr_up     = we && hit(addr, OFS_WATCH_UP);
  assign wr_dn     = we && hit(addr, OFS_WATCH_DN);
  assign wr_mset_a = we && hit(addr, OFS_MSET_A);
  assign wr_mclr_a = we && hit(addr, OFS_MCLR_A);
  assign wr_mset_b = we && hit(addr, OFS_MSET_B);
  assign wr_mclr_b = we && hit(addr, OFS_MCLR_B);
  assign wr_pend   = we && (hit(addr, OFS_PEND_A) || hit(addr, OFS_PEND_B));

  assign ack = wr_pend ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_n    <= '1;
      latch    <= '0;
      watch_lo <= '0;
      watch_hi <= '0;
      watch_up <= '0;
      watch_dn <= '0;
      mask_a   <= '0;
      mask_b   <= '0;
    end else begin
      if (wr_dir) dir_n <= wdata;
      if (wr_latch) latch <= wdata;
      else          latch <= w1_update(latch, wdata, wr_lset, wr_lclr);
      if (wr_lo) watch_lo <= wdata;
      if (wr_hi) watch_hi <= wdata;
      if (wr_up) watch_up <= wdata;
      if (wr_dn) watch_dn <= wdata;
      mask_a <= w1_update(mask_a, wdata, wr_mset_a, wr_mclr_a);
      mask_b <= w1_update(mask_b, wdata, wr_mset_b, wr_mclr_b);
    end
  end

  always_comb begin
    rdata = '0;
    if      (hit(addr, OFS_ID))                               rdata = W'(ID_VALUE);
    else if (hit(addr, OFS_RAW_A) || hit(addr, OFS_RAW_B))    rdata = status;
    else if (hit(addr, OFS_PEND_A))                           rdata = status & mask_a;
    else if (hit(addr, OFS_PEND_B))                           rdata = status & mask_b;
    else if (hit(addr, OFS_MSET_A) || hit(addr, OFS_MCLR_A))  rdata = mask_a;
    else if (hit(addr, OFS_MSET_B) || hit(addr, OFS_MCLR_B))  rdata = mask_b;
    else if (hit(addr, OFS_DIR))                              rdata = dir_n;
    else if (hit(addr, OFS_SAMPLE))                           rdata = cur;
    else if (hit(addr, OFS_LATCH))                            rdata = latch;
    else if (hit(addr, OFS_WATCH_LO))                         rdata = watch_lo;
    else if (hit(addr, OFS_WATCH_HI))                         rdata = watch_hi;
    else if (hit(addr, OFS_WATCH_UP))                         rdata = watch_up;
    else if (hit(addr, OFS_WATCH_DN))                         rdata = watch_dn;
  end

  assert_latch_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lset |=> ((latch & $past(wdata)) == $past(wdata)));

  assert_latch_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lclr |=> ((latch & $past(wdata)) == '0));

  assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset_a |=> ((mask_a & $past(wdata)) == $past(wdata)));

  assert_mask_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mset_b || wr_mclr_b) |=> $stable(mask_b));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = BANK_PINS,
  parameter int unsigned ADDR_W   = BANK_ADDR_W,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe_n,
  output logic                irq0,
  output logic                irq1
);
  logic [NUM_PINS-1:0] cur, prev, status, ack;
  logic [NUM_PINS-1:0] watch_lo, watch_hi, watch_up, watch_dn, mask_a, mask_b;

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev)
  );

  gpio_bus_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cur(cur), .status(status), .rdata(bus_rdata), .dir_n(pin_oe_n), .latch(pin_out),
    .watch_lo(watch_lo), .watch_hi(watch_hi), .watch_up(watch_up), .watch_dn(watch_dn),
    .mask_a(mask_a), .mask_b(mask_b), .ack(ack)
  );

  gpio_evt_status #(.W(NUM_PINS)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
    .watch_lo(watch_lo), .watch_hi(watch_hi), .watch_up(watch_up), .watch_dn(watch_dn),
    .ack(ack), .mask_a(mask_a), .mask_b(mask_b),
    .status(status), .irq0(irq0), .irq1(irq1)
  );

  assert_rev_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_ID)) |-> (bus_rdata == NUM_PINS'(ID_VALUE)));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe_n;
  logic        irq0, irq1;

  int vecs = 0;
  int fails = 0;
  bit done = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq0(irq0), .irq1(irq1)
  );

  // Behavioural reference state
  bit [31:0] q1, q2, qold, m_dir, m_lat, m_lo, m_hi, m_up, m_dn, m_ma, m_mb, m_st;
  bit m_i0, m_i1;

  always @(posedge clk) begin
    if (!rst_n) begin
      q1 = 0; q2 = 0; qold = 0; m_dir = '1; m_lat = 0; m_lo = 0; m_hi = 0;
      m_up = 0; m_dn = 0; m_ma = 0; m_mb = 0; m_st = 0; m_i0 = 0; m_i1 = 0;
    end else begin
      bit [31:0] evt, clrv;
      evt = 0; clrv = 0;
      for (int i = 0; i < 32; i++) begin
        bit hit;
        hit = (m_lo[i] && !q2[i]) || (m_hi[i] && q2[i]) ||
              (m_up[i] && q2[i] && !qold[i]) || (m_dn[i] && !q2[i] && qold[i]);
        evt[i] = hit;
      end
      m_i0 = (m_st & m_ma) != 0;
      m_i1 = (m_st & m_mb) != 0;
      if (bus_we) begin
        case (int'(bus_addr))
          'h02C, 'h030: clrv = bus_wdata;
          'h034: m_ma = m_ma | bus_wdata;
          'h03C: m_ma = m_ma & ~bus_wdata;
          'h038: m_mb = m_mb | bus_wdata;
          'h040: m_mb = m_mb & ~bus_wdata;
          'h134: m_dir = bus_wdata;
          'h13C: m_lat = bus_wdata;
          'h140: m_lo = bus_wdata;
          'h144: m_hi = bus_wdata;
          'h148: m_up = bus_wdata;
          'h14C: m_dn = bus_wdata;
          'h190: m_lat = m_lat & ~bus_wdata;
          'h194: m_lat = m_lat | bus_wdata;
          default: ;
        endcase
      end
      m_st = (m_st & ~clrv) | evt;
      qold = q2; q2 = q1; q1 = pin_in;
    end
  end

  function automatic bit [31:0] model_read(int a);
    case (a)
      'h000: return 32'h5060_0801;
      'h024, 'h028: return m_st;
      'h02C: return m_st & m_ma;
      'h030: return m_st & m_mb;
      'h034, 'h03C: return m_ma;
      'h038, 'h040: return m_mb;
      'h134: return m_dir;
      'h138: return q2;
      'h13C: return m_lat;
      'h140: return m_lo;
      'h144: return m_hi;
      'h148: return m_up;
      'h14C: return m_dn;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      'h000: return "R2";
      'h024, 'h028, 'h02C, 'h030: return "R9";
      'h034, 'h038, 'h03C, 'h040: return "R10";
      'h134: return "R3";
      'h138: return "R6";
      'h13C: return "R4";
      'h140, 'h144: return "R7";
      'h148, 'h14C: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %08h expected %08h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag_of(int'(bus_addr)), bus_rdata, model_read(int'(bus_addr)));
    chk("R4", pin_out, m_lat);
    chk("R3", pin_oe_n, m_dir);
    chk("R11", {31'b0, irq0}, {31'b0, m_i0});
    chk("R11", {31'b0, irq1}, {31'b0, m_i1});
  endtask

  task automatic tick();
    @(negedge clk);
    if (model_on) compare();
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 12'(a); bus_we = 1'b1; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(int a);
    bus_addr = 12'(a);
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  localparam int NOFS = 20;
  int ofs_list [NOFS] = '{'h000, 'h024, 'h028, 'h02C, 'h030, 'h034, 'h038, 'h03C,
                          'h040, 'h134, 'h138, 'h13C, 'h140, 'h144, 'h148, 'h14C,
                          'h190, 'h194, 'h1F0, 'h004};

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 12'h134;
    @(negedge clk);
    // R1 reset state
    chk("R1", bus_rdata, 32'hFFFF_FFFF);
    chk("R1", pin_out, 32'h0);
    chk("R1", {30'b0, irq1, irq0}, 32'h0);
    bus_addr = 12'h024;
    @(negedge clk);
    chk("R1", bus_rdata, 32'h0);
    model_on = 1;

    // R2 identity, unmapped space
    rd('h000);
    wr('h000, 32'h1234_5678); rd('h000);
    wr('h1F0, 32'hFFFF_FFFF); rd('h1F0);
    chk("R2", bus_rdata, 32'h0);
    wr('h024, 32'hFFFF_FFFF); rd('h024);

    // R3 / R4 / R5 direction and latch
    wr('h134, 32'h0F0F_00FF); rd('h134);
    wr('h13C, 32'hA5A5_5A5A); rd('h13C);
    wr('h194, 32'h0000_0005); rd('h13C);
    chk("R5", pin_out, 32'hA5A5_5A5F);
    wr('h190, 32'hA000_0000); rd('h13C);
    chk("R5", pin_out, 32'h05A5_5A5F);

    // R6 synchronized input
    pin_in = 32'hDEAD_BEEF;
    rd('h138); rd('h138);
    chk("R6", bus_rdata, 32'hDEAD_BEEF);
    pin_in = 32'h0;
    rd('h138); rd('h138);

    // R10 masks
    wr('h034, 32'h0000_00F0); wr('h038, 32'h0000_0F00);
    wr('h03C, 32'h0000_0030); rd('h034); rd('h040);
    chk("R10", bus_rdata, 32'h0000_0F00);

    // R7 high level on pin 5, line 0 enabled for it
    wr('h034, 32'h0000_0020);
    wr('h144, 32'h0000_0020);
    pin_in[5] = 1'b1;
    repeat (5) rd('h02C);
    chk("R11", {31'b0, irq0}, 32'h1);
    wr('h02C, 32'h0000_0020); rd('h024);
    chk("R7", bus_rdata & 32'h20, 32'h20);
    pin_in[5] = 1'b0;
    repeat (3) rd('h024);
    wr('h02C, 32'h0000_0020); rd('h024);
    chk("R7", bus_rdata & 32'h20, 32'h0);
    wr('h144, 32'h0);
    // low level on pin 6
    wr('h140, 32'h0000_0040); rd('h024);
    chk("R7", bus_rdata & 32'h40, 32'h40);
    wr('h140, 32'h0); wr('h02C, 32'hFFFF_FFFF); rd('h024);

    // R8 edges: rising pin 8, both edges pin 9, line 1
    wr('h148, 32'h0000_0300); wr('h14C, 32'h0000_0200);
    wr('h038, 32'h0000_0300);
    pin_in[8] = 1'b1; pin_in[9] = 1'b1;
    repeat (4) rd('h030);
    chk("R8", bus_rdata, 32'h0000_0300);
    pin_in[8] = 1'b0; pin_in[9] = 1'b0;
    wr('h030, 32'h0000_0300);
    repeat (4) rd('h024);
    chk("R8", bus_rdata & 32'h300, 32'h200);
    wr('h030, 32'h0000_0000); rd('h024);
    chk("R9", bus_rdata & 32'h300, 32'h200);
    wr('h02C, 32'h0000_0200); rd('h024);

    // R12 acknowledge collides with a new rising edge on pin 3
    wr('h148, 32'h0000_0008);
    pin_in[3] = 1'b1;
    tick(); tick();
    wr('h02C, 32'h0000_0008);
    rd('h024);
    chk("R12", bus_rdata & 32'h8, 32'h8);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom_range(0, NOFS-1);
      if ($urandom_range(0, 3) == 0) pin_in = $urandom;
      bus_addr = 12'(ofs_list[k]);
      bus_we = ($urandom_range(0, 1) == 1);
      bus_wdata = ($urandom_range(0, 2) == 0) ? 32'($urandom) : (32'h1 << $urandom_range(0, 31));
      tick();
    end
    bus_we = 1'b0;
    rd('h024);

    done = 1;
    summary();
    $finish;
  end
endmodule